// File: doc/BRIEF.md
# Clock Source and Power Mode Controller

This block sits beside a microcontroller core and decides which oscillator is running, which clocks are allowed to tick, and which operating mode the device is in. Software sets two power bits (idle and power-down) and four oscillator bits (crystal enable, high-speed RC enable, clock select, low-speed RC off). The block turns that six-bit state into enables for three oscillators, separate enables for the CPU clock and the peripheral clock, a mode code, and a flag for combinations that leave no clock running.

Idle and power-down are entered by writing the power bits. Pending-and-enabled interrupt requests end them. They pass through a configurable synchronizer first. Any request line ends idle, while only the external lines end power-down. On exit, hardware clears the power bit and leaves the oscillator bits alone, so the oscillator that was in use before the sleep resumes. After reset, the reset-oscillator input decides whether the device starts on the crystal or on the high-speed RC.

Top module: `pmc_clock_power_ctl`

## Requirements
- R1: While reset is held, the power bits clear and clock select copies `rst_osc_sel`. The matching oscillator enable becomes 1 and the other becomes 0, and low-speed RC off becomes 0. `osc_state` then reads 4'b0101 (crystal) or 4'b0010 (RC), and the mode is 0 or 1. Bit map of `osc_state`: [0] crystal enable, [1] high-speed RC enable, [2] clock select, [3] low-speed RC off.
- R2: A write on `pwr_wr_en` loads `pwr_wr_data` into `pwr_state` at that clock edge. Bit 0 is idle and bit 1 is power-down.
- R3: With both power bits 0, the mode is 0 (normal A, `clk_src`=1) when clock select and crystal enable are both 1. The mode is 1 (normal B, `clk_src`=2) when clock select is 0 and high-speed RC enable is 1. CPU and peripheral clocks are both enabled.
- R4: With both power bits 0, if the selected main oscillator is disabled and low-speed RC off is 0, the mode is 2 (rescue). `clk_src` is 3 and both clocks are enabled.
- R5: Without power-down, if the selected main oscillator is disabled and low-speed RC off is 1, the mode is 8. `invalid` is 1, `clk_src` is 0, and both clocks are disabled.
- R6: With idle set and power-down clear, the mode is 3 (idle A, source 1) or 4 (idle B, source 2) when the selected main oscillator is enabled. Otherwise, if the low-speed RC is on, the mode is 5 (idle on low-speed RC, source 3). The CPU clock is off and the peripheral clock is on.
- R7: With power-down set, crystal and high-speed RC enables and both clocks are 0. Low-speed RC off = 0 gives mode 6 with `lsrc_en`=1. Low-speed RC off = 1 gives mode 7 with `lsrc_en`=0.
- R8: With idle set and power-down clear, an assertion on any `irq_req` line clears the idle bit SYNC_STAGES+1 edges after it is first sampled.
- R9: Power-down is cleared only by the external lines `irq_req[EXT_IRQ_CNT-1:0]`, with the same latency. Other lines leave power-down set.
- R10: A wake-up exit never changes `osc_state`; only an oscillator write does.
- R11: Outside power-down, `xtal_en` and `hsrc_en` follow their bits and `lsrc_en` is the inverse of low-speed RC off.
- R12: When a power write and a wake-up fall on the same edge, the write wins. The wake-up then clears the bit on a later edge if the request is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_osc_sel | input | 1 | Reset oscillator choice: 1 crystal, 0 high-speed RC |
| pwr_wr_en | input | 1 | Power register write strobe |
| pwr_wr_data | input | 2 | [0] idle, [1] power-down |
| osc_wr_en | input | 1 | Oscillator register write strobe |
| osc_wr_data | input | 4 | [0] crystal en, [1] HS RC en, [2] clock select, [3] LS RC off |
| irq_req | input | NUM_IRQ | Pending-and-enabled requests; low EXT_IRQ_CNT lines are external |
| pwr_state | output | 2 | Current power bits |
| osc_state | output | 4 | Current oscillator bits |
| xtal_en | output | 1 | Crystal oscillator enable |
| hsrc_en | output | 1 | High-speed RC oscillator enable |
| lsrc_en | output | 1 | Low-speed RC oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| clk_src | output | 2 | 0 none, 1 crystal, 2 HS RC, 3 LS RC |
| mode | output | 4 | Decoded mode code |
| invalid | output | 1 | No usable clock selected |

## Verification
The bench builds the block with NUM_IRQ = 6, EXT_IRQ_CNT = 2 and SYNC_STAGES = 2. This setup leaves four non-external lines to show that power-down ignores them. The two-stage synchronizer makes the wake latency three edges, so the bench can test a write and a wake landing on the same edge. Random oscillator and power codes cover the full 64-entry decode space, and both settings of the reset-oscillator input are used.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   localparam int PWR_W = 2;
   localparam int OSC_W = 4;

   localparam int PB_IDLE = 0;
   localparam int PB_PD   = 1;

   localparam int OB_XEN  = 0;
   localparam int OB_HEN  = 1;
   localparam int OB_CSEL = 2;
   localparam int OB_LOFF = 3;

   typedef enum logic [3:0] {
      MD_NORM_XTAL = 4'd0,
      MD_NORM_HSRC = 4'd1,
      MD_RESCUE    = 4'd2,
      MD_IDLE_XTAL = 4'd3,
      MD_IDLE_HSRC = 4'd4,
      MD_IDLE_LSRC = 4'd5,
      MD_PD_WDOG   = 4'd6,
      MD_PD_TOTAL  = 4'd7,
      MD_NO_CLOCK  = 4'd8
   } pmc_mode_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_XTAL = 2'd1,
      SRC_HSRC = 2'd2,
      SRC_LSRC = 2'd3
   } pmc_src_e;

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] req_in,
   output logic [WIDTH-1:0] req_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pmc_wake_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("pmc_wake_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign req_out = req_in;
   end else begin : g_flops
      logic [WIDTH-1:0] stg_q [STAGES];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         end else begin
            stg_q[0] <= req_in;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end

      assign req_out = stg_q[STAGES-1];
   end

endmodule

// File: rtl/pmc_ctl_regs.sv
module pmc_ctl_regs
   import pmc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rst_osc_sel,
   input  logic             pwr_wr_en,
   input  logic [PWR_W-1:0] pwr_wr_data,
   input  logic             osc_wr_en,
   input  logic [OSC_W-1:0] osc_wr_data,
   input  logic             wake_any,
   input  logic             wake_ext,
   output logic [PWR_W-1:0] pwr_q,
   output logic [OSC_W-1:0] osc_q
);

   logic [PWR_W-1:0] pwr_after_wake;
   logic [OSC_W-1:0] osc_rst_val;

   // Reset value: start on the oscillator named by the configuration pin.
   always_comb begin
      osc_rst_val          = '0;
      osc_rst_val[OB_CSEL] = rst_osc_sel;
      osc_rst_val[OB_XEN]  = rst_osc_sel;
      osc_rst_val[OB_HEN]  = ~rst_osc_sel;
      osc_rst_val[OB_LOFF] = 1'b0;
   end

   // Wake clearing: power-down dominates; idle only ends once power-down is gone.
   always_comb begin
      pwr_after_wake = pwr_q;
      if (pwr_q[PB_PD]) begin
         if (wake_ext) pwr_after_wake[PB_PD] = 1'b0;
      end else if (pwr_q[PB_IDLE] && wake_any) begin
         pwr_after_wake[PB_IDLE] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_q <= '0;
      end else if (pwr_wr_en) begin
         pwr_q <= pwr_wr_data;
      end else begin
         pwr_q <= pwr_after_wake;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         osc_q <= osc_rst_val;
      end else if (osc_wr_en) begin
         osc_q <= osc_wr_data;
      end
   end

endmodule

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
   import pmc_pkg::*;
(
   input  logic [PWR_W-1:0] pwr,
   input  logic [OSC_W-1:0] osc,
   output logic             xtal_en,
   output logic             hsrc_en,
   output logic             lsrc_en,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output pmc_src_e         clk_src,
   output pmc_mode_e        mode
);

   logic     sel_xtal;
   logic     main_ok;
   logic     lsrc_on;
   pmc_src_e main_src;

   assign sel_xtal = osc[OB_CSEL];
   assign main_ok  = sel_xtal ? osc[OB_XEN] : osc[OB_HEN];
   assign lsrc_on  = ~osc[OB_LOFF];
   assign main_src = sel_xtal ? SRC_XTAL : SRC_HSRC;

   always_comb begin
      mode       = MD_NO_CLOCK;
      clk_src    = SRC_NONE;
      cpu_clk_en = 1'b0;
      per_clk_en = 1'b0;
      xtal_en    = osc[OB_XEN];
      hsrc_en    = osc[OB_HEN];
      lsrc_en    = lsrc_on;

      if (pwr[PB_PD]) begin
         xtal_en = 1'b0;
         hsrc_en = 1'b0;
         mode    = lsrc_on ? MD_PD_WDOG : MD_PD_TOTAL;
      end else if (!main_ok && !lsrc_on) begin
         mode = MD_NO_CLOCK;
      end else if (pwr[PB_IDLE]) begin
         per_clk_en = 1'b1;
         if (main_ok) begin
            mode    = sel_xtal ? MD_IDLE_XTAL : MD_IDLE_HSRC;
            clk_src = main_src;
         end else begin
            mode    = MD_IDLE_LSRC;
            clk_src = SRC_LSRC;
         end
      end else begin
         per_clk_en = 1'b1;
         cpu_clk_en = 1'b1;
         if (main_ok) begin
            mode    = sel_xtal ? MD_NORM_XTAL : MD_NORM_HSRC;
            clk_src = main_src;
         end else begin
            mode    = MD_RESCUE;
            clk_src = SRC_LSRC;
         end
      end
   end

endmodule

// File: rtl/pmc_clock_power_ctl.sv
module pmc_clock_power_ctl #(
   parameter int NUM_IRQ     = 6,
   parameter int EXT_IRQ_CNT = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_osc_sel,
   input  logic               pwr_wr_en,
   input  logic [1:0]         pwr_wr_data,
   input  logic               osc_wr_en,
   input  logic [3:0]         osc_wr_data,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic [1:0]         pwr_state,
   output logic [3:0]         osc_state,
   output logic               xtal_en,
   output logic               hsrc_en,
   output logic               lsrc_en,
   output logic               cpu_clk_en,
   output logic               per_clk_en,
   output logic [1:0]         clk_src,
   output logic [3:0]         mode,
   output logic               invalid
);
   import pmc_pkg::*;

   if (EXT_IRQ_CNT < 1 || EXT_IRQ_CNT > NUM_IRQ) begin : g_bad_ext
      $error("pmc_clock_power_ctl: EXT_IRQ_CNT must be 1..NUM_IRQ");
   end

   logic [NUM_IRQ-1:0] irq_s;
   logic               wake_any_s;
   logic               wake_ext_s;
   pmc_src_e           src_e;
   pmc_mode_e          mode_e;

   pmc_wake_sync #(
      .WIDTH  (NUM_IRQ),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (irq_req),
      .req_out (irq_s)
   );

   assign wake_any_s = |irq_s;
   assign wake_ext_s = |irq_s[EXT_IRQ_CNT-1:0];

   pmc_ctl_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .rst_osc_sel (rst_osc_sel),
      .pwr_wr_en   (pwr_wr_en),
      .pwr_wr_data (pwr_wr_data),
      .osc_wr_en   (osc_wr_en),
      .osc_wr_data (osc_wr_data),
      .wake_any    (wake_any_s),
      .wake_ext    (wake_ext_s),
      .pwr_q       (pwr_state),
      .osc_q       (osc_state)
   );

   pmc_mode_decode u_dec (
      .pwr        (pwr_state),
      .osc        (osc_state),
      .xtal_en    (xtal_en),
      .hsrc_en    (hsrc_en),
      .lsrc_en    (lsrc_en),
      .cpu_clk_en (cpu_clk_en),
      .per_clk_en (per_clk_en),
      .clk_src    (src_e),
      .mode       (mode_e)
   );

   assign clk_src = src_e;
   assign mode    = mode_e;
   assign invalid = (mode_e == MD_NO_CLOCK);

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
   import pmc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_wr_en,
   input logic [1:0] pwr_wr_data,
   input logic       osc_wr_en,
   input logic [1:0] pwr_state,
   input logic [3:0] osc_state,
   input logic       xtal_en,
   input logic       hsrc_en,
   input logic       lsrc_en,
   input logic       cpu_clk_en,
   input logic       per_clk_en,
   input logic [3:0] mode,
   input logic       invalid,
   input logic       wake_any_s
);

   logic live_q;

   always_ff @(posedge clk) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   // R2 R12
   pwr_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(pwr_wr_en)) |-> (pwr_state == $past(pwr_wr_data)));

   // R5
   no_clock_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> (!cpu_clk_en && !per_clk_en));

   // R6
   idle_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b01 && !invalid) |-> (!cpu_clk_en && per_clk_en));

   // R7
   pd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state[1] |-> (!xtal_en && !hsrc_en && !cpu_clk_en && !per_clk_en
                        && lsrc_en == !osc_state[3]));

   // R8
   idle_exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(pwr_state[0]) && !pwr_state[0] && !$past(pwr_wr_en))
         |-> $past(wake_any_s));

   // R10
   osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !$past(osc_wr_en)) |-> (osc_state == $past(osc_state)));

   // R11
   osc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_state[1] |-> (xtal_en == osc_state[0] && hsrc_en == osc_state[1]
                         && lsrc_en == !osc_state[3]));

   // R7
   pd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state[1] |-> (mode == MD_PD_WDOG || mode == MD_PD_TOTAL));

endmodule

bind pmc_clock_power_ctl pmc_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_wr_en   (pwr_wr_en),
   .pwr_wr_data (pwr_wr_data),
   .osc_wr_en   (osc_wr_en),
   .pwr_state   (pwr_state),
   .osc_state   (osc_state),
   .xtal_en     (xtal_en),
   .hsrc_en     (hsrc_en),
   .lsrc_en     (lsrc_en),
   .cpu_clk_en  (cpu_clk_en),
   .per_clk_en  (per_clk_en),
   .mode        (mode),
   .invalid     (invalid),
   .wake_any_s  (wake_any_s)
);

// File: tb/sim_pmc_clock_power_ctl.sv
`timescale 1ns/1ps
module sim_pmc_clock_power_ctl;

   localparam int NIRQ = 6;
   localparam int NEXT = 2;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rst_osc_sel = 1'b1;
   logic            pwr_wr_en = 1'b0;
   logic [1:0]      pwr_wr_data = '0;
   logic            osc_wr_en = 1'b0;
   logic [3:0]      osc_wr_data = '0;
   logic [NIRQ-1:0] irq_req = '0;
   logic [1:0]      pwr_state;
   logic [3:0]      osc_state;
   logic            xtal_en, hsrc_en, lsrc_en, cpu_clk_en, per_clk_en, invalid;
   logic [1:0]      clk_src;
   logic [3:0]      mode;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   pmc_clock_power_ctl #(.NUM_IRQ(NIRQ), .EXT_IRQ_CNT(NEXT), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .rst_osc_sel(rst_osc_sel),
      .pwr_wr_en(pwr_wr_en), .pwr_wr_data(pwr_wr_data),
      .osc_wr_en(osc_wr_en), .osc_wr_data(osc_wr_data), .irq_req(irq_req),
      .pwr_state(pwr_state), .osc_state(osc_state),
      .xtal_en(xtal_en), .hsrc_en(hsrc_en), .lsrc_en(lsrc_en),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .clk_src(clk_src), .mode(mode), .invalid(invalid)
   );

   // {xtal, hsrc, lsrc, cpu, per, src[1:0], mode[3:0], invalid}
   function automatic logic [11:0] model(input logic [1:0] p, input logic [3:0] o);
      logic xe, he, cs, off, sel_on, x, h, l, c, q;
      logic [1:0] s;
      logic [3:0] m;
      xe = o[0]; he = o[1]; cs = o[2]; off = o[3];
      sel_on = cs ? xe : he;
      x = xe; h = he; l = !off; c = 0; q = 0; s = 0;
      if (p[1]) begin
         x = 0; h = 0; m = off ? 4'd7 : 4'd6;
      end else if (!sel_on && off) begin
         m = 4'd8;
      end else if (p[0]) begin
         q = 1;
         m = sel_on ? (cs ? 4'd3 : 4'd4) : 4'd5;
         s = sel_on ? (cs ? 2'd1 : 2'd2) : 2'd3;
      end else begin
         q = 1; c = 1;
         m = sel_on ? (cs ? 4'd0 : 4'd1) : 4'd2;
         s = sel_on ? (cs ? 2'd1 : 2'd2) : 2'd3;
      end
      return {x, h, l, c, q, s, m, (m == 4'd8)};
   endfunction

   function automatic string req_of(input logic [11:0] e);
      case (e[4:1])
         4'd0, 4'd1: return "R3";
         4'd2: return "R4";
         4'd8: return "R5";
         4'd6, 4'd7: return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_outputs(input logic [1:0] p, input logic [3:0] o);
      logic [11:0] e;
      e = model(p, o);
      chk(req_of(e), {xtal_en, hsrc_en, lsrc_en, cpu_clk_en, per_clk_en,
                      clk_src, mode, invalid}, e);
      if (!p[1]) chk("R11", {xtal_en, hsrc_en, lsrc_en}, {o[0], o[1], !o[3]});
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_osc(input logic [3:0] d);
      osc_wr_en = 1; osc_wr_data = d;
      step(1);
      osc_wr_en = 0;
   endtask

   task automatic wr_pwr(input logic [1:0] d);
      pwr_wr_en = 1; pwr_wr_data = d;
      step(1);
      pwr_wr_en = 0;
   endtask

   task automatic do_reset(input logic sel);
      rst_osc_sel = sel; rst_n = 0;
      step(3);
      rst_n = 1;
      step(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0C1C_5EED));
      @(negedge clk);

      // R1: reset on crystal, then on RC
      do_reset(1'b1);
      chk("R1", {pwr_state, osc_state}, {2'b00, 4'b0101});
      chk_outputs(2'b00, 4'b0101);
      do_reset(1'b0);
      chk("R1", {pwr_state, osc_state}, {2'b00, 4'b0010});
      chk_outputs(2'b00, 4'b0010);

      // R3 R4 R5 directed decode
      wr_osc(4'b0101); chk_outputs(2'b00, 4'b0101);
      wr_osc(4'b0010); chk_outputs(2'b00, 4'b0010);
      wr_osc(4'b0110); chk_outputs(2'b00, 4'b0110);  // R4 rescue, HS RC on but not selected
      wr_osc(4'b0000); chk_outputs(2'b00, 4'b0000);  // R4
      wr_osc(4'b1100); chk_outputs(2'b00, 4'b1100);  // R5
      wr_osc(4'b1001); chk_outputs(2'b00, 4'b1001);  // R5

      // R2 R6 R8 R10: idle B, wake on a non-external line
      wr_osc(4'b0010);
      wr_pwr(2'b01);
      chk("R2", pwr_state, 2'b01);
      chk_outputs(2'b01, 4'b0010);
      irq_req = 6'b10_0000;
      step(LAT - 1);
      chk("R8", pwr_state, 2'b01);
      step(1);
      chk("R8", pwr_state, 2'b00);
      chk("R10", osc_state, 4'b0010);
      chk_outputs(2'b00, 4'b0010);
      irq_req = '0; step(SYNC + 1);

      // R6 idle on low-speed RC
      wr_osc(4'b0100);
      wr_pwr(2'b01);
      chk_outputs(2'b01, 4'b0100);
      wr_pwr(2'b00);

      // R7 R9 R10: power-down with watchdog oscillator
      wr_osc(4'b0111);
      wr_pwr(2'b10);
      chk("R2", pwr_state, 2'b10);
      chk_outputs(2'b10, 4'b0111);
      irq_req = 6'b00_1100;            // non-external lines only
      step(LAT + 3);
      chk("R9", pwr_state, 2'b10);
      irq_req = 6'b00_0010;            // external line 1
      step(LAT);
      chk("R9", pwr_state, 2'b00);
      chk("R10", osc_state, 4'b0111);
      chk_outputs(2'b00, 4'b0111);
      irq_req = '0; step(SYNC + 1);

      // R7 total power-down, external line 0
      wr_osc(4'b1101);
      wr_pwr(2'b10);
      chk_outputs(2'b10, 4'b1101);
      irq_req = 6'b00_0001;
      step(LAT);
      chk("R9", pwr_state, 2'b00);
      chk("R10", osc_state, 4'b1101);
      irq_req = '0; step(SYNC + 1);

      // R12: write meets an active wake
      wr_osc(4'b0101);
      irq_req = 6'b01_0000;
      step(LAT);
      wr_pwr(2'b01);
      chk("R12", pwr_state, 2'b01);
      step(1);
      chk("R12", pwr_state, 2'b00);
      irq_req = '0; step(SYNC + 1);

      // Random decode sweep
      for (int i = 0; i < 300; i++) begin
         logic [3:0] o;
         logic [1:0] p;
         o = 4'($urandom_range(0, 15));
         p = 2'($urandom_range(0, 3));
         wr_osc(o);
         wr_pwr(p);
         chk("R2", pwr_state, p);
         chk_outputs(p, o);
         wr_pwr(2'b00);
         chk_outputs(2'b00, o);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule